// File: doc/BRIEF.md
# Clock-Synchronous Burst ROM Read Controller

This controller connects a 32-bit host to a clock-synchronous burst ROM that sits on a 16-bit data bus. Every read is run as a full burst of eight halfword beats, whatever width the host asked for. The beats start at the 16-byte aligned base of the requested address and climb in order. Only the one or two beats the host needs are kept. The rest are fetched from the memory and dropped. The number of wait cycles before the first beat's data is set on one input, and the number before each later beat's data is set on another. While the memory holds its WAIT line high, the current data cycle is stretched.

Writes do not burst. A write is a single 16-bit access: the read/write line is low, the frame strobe stays released, the first-beat wait count applies, and WAIT can stretch the data cycle. The host uses a simple handshake. A request is taken when the block is idle. A single-cycle response pulse comes back once the whole access has finished, and for a read that includes every discarded beat.

States: IDLE, RD_START, RD_WAIT, RD_DATA, WR_START, WR_WAIT, WR_DATA, RESP. The transitions are:
- take-read (IDLE to RD_START) and take-write (IDLE to WR_START).
- no-wait (RD_START to RD_DATA, WR_START to WR_DATA) when the wait count is zero, and wait (START to WAIT) otherwise.
- wait-done (WAIT to DATA) once the count runs out.
- stretch (DATA to DATA) while WAIT is high.
- next-beat (RD_DATA to RD_START).
- burst-done (RD_DATA to RESP) after beat 7.
- write-done (WR_DATA to RESP).
- respond (RESP to IDLE).

Top module: `brom_burst_ctrl`

## Requirements
- R1: After reset, and whenever idle, `req_ready` is 1, `mem_cs_n`, `mem_frame_n` and `mem_bs_n` are 1, `mem_rd_wr` is 1, `mem_wdata_oe` is 0 and `rsp_valid` is 0.
- R2: A read of either width runs exactly 8 beats. Beat b presents `mem_addr` = {req_addr[AW-1:4], b[2:0], 1'b0}, for b = 0 to 7 in rising order.
- R3: In a read, beat 0 spends `cfg_first_wait` cycles between its start cycle and its data cycle, and each later beat spends `cfg_next_wait` cycles there.
- R4: `mem_bs_n` is low for exactly one clock, the start cycle of each beat, and is high in every other cycle.
- R5: During a read, `mem_cs_n` and `mem_frame_n` are low without a break from the first start cycle to the last data cycle. Both are high in the response cycle.
- R6: While `mem_wait` is 1 in a data cycle, that data cycle repeats and `mem_addr` holds. Data is taken in the first data cycle in which `mem_wait` is 0. `mem_wait` has no effect in start or wait cycles.
- R7: A 16-bit read (`req_wide`=0) returns the beat with index req_addr[3:1] in `rsp_rdata[15:0]`, with `rsp_rdata[31:16]` = 0.
- R8: A 32-bit read (`req_wide`=1) returns {beat 2k, beat 2k+1} with k = req_addr[3:2], the lower-addressed halfword in bits 31:16. req_addr[1] is ignored.
- R9: `rsp_valid` is high for one cycle, the cycle right after the final data cycle. `req_ready` is 0 from the cycle after a request is taken through that response cycle. `req_valid` has no effect while `req_ready` is 0.
- R10: A write runs one beat with `mem_rd_wr`=0, `mem_frame_n`=1, `mem_cs_n`=0, `mem_addr`=req_addr, `mem_wdata`=req_wdata and `mem_wdata_oe`=1. It waits `cfg_first_wait` cycles and then responds with `rsp_rdata` = 0.
- R11: A wait count of 0 puts the data cycle in the clock right after the start cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | Read width: 1 = 32 bits, 0 = 16 bits |
| req_addr | input | AW | Byte address |
| req_wdata | input | 16 | Write halfword |
| cfg_first_wait | input | WW | Wait cycles before the first beat's data (also used for writes) |
| cfg_next_wait | input | WW | Wait cycles before the data of later beats |
| mem_wait | input | 1 | Memory stretch request, active high |
| mem_rdata | input | 16 | Memory read data |
| req_ready | output | 1 | Block idle, request is taken |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read result |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_wdata_oe | output | 1 | Write data drive enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_frame_n | output | 1 | Burst frame, active low |
| mem_rd_wr | output | 1 | 1 = read, 0 = write |
| mem_bs_n | output | 1 | Beat start strobe, active low |

## Verification
The assertions assume that both wait-count inputs stay constant from the moment a request is taken until its response, and one assertion checks this. They also assume that the memory drives `mem_wait` only as a stretch request, so it matters only in data cycles. The bench meets both assumptions. It changes the configuration only while the block is idle. It computes a per-cycle schedule of memory waits, strobes and addresses for each access and drives `mem_wait` from that schedule, which puts stretches in data cycles and also sets `mem_wait` in wait cycles to show that it has no effect there.

// File: rtl/brom_pkg.sv
package brom_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_START,
        ST_RD_WAIT,
        ST_RD_DATA,
        ST_WR_START,
        ST_WR_WAIT,
        ST_WR_DATA,
        ST_RESP
    } brom_state_t;
endpackage

// File: rtl/brom_wait_cnt.sv
module brom_wait_cnt #(
    parameter int WW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [WW-1:0] load_val,
    input  logic          dec,
    output logic          last
);
    logic [WW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == WW'(1)) || (cnt_q == '0);
endmodule

// File: rtl/brom_beat_pick.sv
module brom_beat_pick #(
    parameter int BURST_LEN = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          capture,
    input  logic          wide,
    input  logic [$clog2(BURST_LEN)-1:0] beat,
    input  logic [$clog2(BURST_LEN)-1:0] sel,
    input  logic [15:0]   din,
    output logic [31:0]   word
);
    localparam int BB = $clog2(BURST_LEN);

    logic [15:0] hi_q, lo_q;
    logic        hit_hi, hit_lo;

    generate
        if (BB > 1) begin : g_pair
            assign hit_hi = wide  && (beat == {sel[BB-1:1], 1'b0});
            assign hit_lo = wide  ? (beat == {sel[BB-1:1], 1'b1}) : (beat == sel);
        end else begin : g_single
            assign hit_hi = wide && (beat == 1'b0);
            assign hit_lo = wide ? (beat == 1'b1) : (beat == sel);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (clear) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (capture) begin
            if (hit_hi) hi_q <= din;
            if (hit_lo) lo_q <= din;
        end
    end

    assign word = {hi_q, lo_q};
endmodule

// File: rtl/brom_burst_ctrl.sv
module brom_burst_ctrl
    import brom_pkg::*;
#(
    parameter int AW        = 24,
    parameter int WW        = 4,
    parameter int BURST_LEN = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_wide,
    input  logic [AW-1:0] req_addr,
    input  logic [15:0]   req_wdata,
    input  logic [WW-1:0] cfg_first_wait,
    input  logic [WW-1:0] cfg_next_wait,
    input  logic          mem_wait,
    input  logic [15:0]   mem_rdata,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [31:0]   rsp_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    output logic          mem_wdata_oe,
    output logic          mem_cs_n,
    output logic          mem_frame_n,
    output logic          mem_rd_wr,
    output logic          mem_bs_n
);
    localparam int BB  = $clog2(BURST_LEN);
    localparam int OFF = BB + 1;

    brom_state_t   state_q, state_nx;
    logic [AW-1:0] addr_q;
    logic          wide_q, wr_q;
    logic [15:0]   wdata_q;
    logic [BB-1:0] beat_q;

    logic          accept, last_beat, wait_last, cnt_load, cnt_dec, capture;
    logic [WW-1:0] beat_wait;

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign last_beat = (beat_q == BB'(BURST_LEN - 1));
    assign beat_wait = (state_q == ST_WR_START || beat_q == '0) ? cfg_first_wait : cfg_next_wait;
    assign cnt_load  = (state_q == ST_RD_START) || (state_q == ST_WR_START);
    assign cnt_dec   = (state_q == ST_RD_WAIT)  || (state_q == ST_WR_WAIT);
    assign capture   = (state_q == ST_RD_DATA)  && !mem_wait;

    brom_wait_cnt #(.WW(WW)) u_wait (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(beat_wait),
        .dec(cnt_dec), .last(wait_last)
    );

    brom_beat_pick #(.BURST_LEN(BURST_LEN)) u_pick (
        .clk(clk), .rst_n(rst_n), .clear(accept), .capture(capture),
        .wide(wide_q), .beat(beat_q), .sel(addr_q[OFF-1:1]),
        .din(mem_rdata), .word(rsp_rdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid) state_nx = req_write ? ST_WR_START : ST_RD_START;
            ST_RD_START: state_nx = (beat_wait == '0) ? ST_RD_DATA : ST_RD_WAIT;
            ST_RD_WAIT:  if (wait_last) state_nx = ST_RD_DATA;
            ST_RD_DATA:  if (!mem_wait) state_nx = last_beat ? ST_RESP : ST_RD_START;
            ST_WR_START: state_nx = (beat_wait == '0) ? ST_WR_DATA : ST_WR_WAIT;
            ST_WR_WAIT:  if (wait_last) state_nx = ST_WR_DATA;
            ST_WR_DATA:  if (!mem_wait) state_nx = ST_RESP;
            ST_RESP:     state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // request capture and beat index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wide_q  <= 1'b0;
            wr_q    <= 1'b0;
            wdata_q <= '0;
            beat_q  <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wide_q  <= req_wide;
            wr_q    <= req_write;
            wdata_q <= req_wdata;
            beat_q  <= '0;
        end else if (capture && !last_beat) begin
            beat_q  <= beat_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        req_ready    = 1'b0;
        rsp_valid    = 1'b0;
        mem_cs_n     = 1'b1;
        mem_frame_n  = 1'b1;
        mem_rd_wr    = 1'b1;
        mem_bs_n     = 1'b1;
        mem_wdata_oe = 1'b0;
        mem_addr     = {addr_q[AW-1:OFF], beat_q, 1'b0};
        mem_wdata    = wdata_q;
        unique case (state_q)
            ST_IDLE:     req_ready = 1'b1;
            ST_RD_START: begin mem_cs_n = 1'b0; mem_frame_n = 1'b0; mem_bs_n = 1'b0; end
            ST_RD_WAIT,
            ST_RD_DATA:  begin mem_cs_n = 1'b0; mem_frame_n = 1'b0; end
            ST_WR_START: begin
                mem_cs_n = 1'b0; mem_rd_wr = 1'b0; mem_bs_n = 1'b0;
                mem_wdata_oe = 1'b1; mem_addr = addr_q;
            end
            ST_WR_WAIT,
            ST_WR_DATA:  begin
                mem_cs_n = 1'b0; mem_rd_wr = 1'b0;
                mem_wdata_oe = 1'b1; mem_addr = addr_q;
            end
            ST_RESP:     rsp_valid = 1'b1;
            default:     ;
        endcase
    end

    // beat-start counter, used by the assertions only
    logic [BB:0] bs_seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                bs_seen_q <= '0;
        else if (accept)           bs_seen_q <= '0;
        else if (!mem_bs_n)        bs_seen_q <= bs_seen_q + 1'b1;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_frame_n && mem_bs_n && !rsp_valid)); // R1
    AST_READ_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !wr_q) |-> (bs_seen_q == (BB+1)'(BURST_LEN))); // R2
    AST_BS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_bs_n |=> mem_bs_n); // R4
    AST_FRAME_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_frame_n |-> !mem_cs_n); // R5
    AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_DATA && mem_wait) |=> (state_q == ST_RD_DATA && $stable(mem_addr))); // R6
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready)); // R9
    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !$past(req_ready)) |-> ($stable(cfg_first_wait) && $stable(cfg_next_wait))); // R3
    AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && wr_q) |-> (bs_seen_q == (BB+1)'(1))); // R10
    AST_WRITE_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_wr |-> (mem_frame_n && mem_wdata_oe)); // R10
endmodule

// File: tb/brom_burst_ctrl_test.sv
module brom_burst_ctrl_test;
    localparam int AW = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          req_valid = 0, req_write = 0, req_wide = 0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic [3:0]    cfg_first_wait = 4'd2, cfg_next_wait = 4'd1;
    logic          mem_wait = 0;
    logic [15:0]   mem_rdata;
    logic          req_ready, rsp_valid, mem_wdata_oe, mem_cs_n, mem_frame_n, mem_rd_wr, mem_bs_n;
    logic [31:0]   rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata;

    brom_burst_ctrl #(.AW(AW), .WW(4), .BURST_LEN(8)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .cfg_first_wait(cfg_first_wait), .cfg_next_wait(cfg_next_wait),
        .mem_wait(mem_wait), .mem_rdata(mem_rdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe), .mem_cs_n(mem_cs_n),
        .mem_frame_n(mem_frame_n), .mem_rd_wr(mem_rd_wr), .mem_bs_n(mem_bs_n)
    );

    function automatic logic [15:0] memf(input logic [AW-1:0] a);
        return 16'h5A00 ^ {a[11:0], a[15:12]};
    endfunction
    assign mem_rdata = memf(mem_addr);

    typedef struct packed {
        logic bs_n, cs_n, fr_n, rw, oe, wt, rsp;
        logic [AW-1:0] addr;
    } cyc_t;

    cyc_t          expq[$];
    logic [31:0]   exp_rdata;
    logic [15:0]   exp_wdata;
    string         rd_tag;
    int            checks = 0, fails = 0;
    bit            done = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // compare one cycle against the model, drive mem_wait from the schedule
    task automatic step();
        cyc_t e;
        @(negedge clk);
        if (expq.size() == 0) begin
            mem_wait = 1'b0;
            chk(req_ready == 1 && mem_cs_n && mem_frame_n && mem_bs_n && mem_rd_wr && !mem_wdata_oe && !rsp_valid,
                "R1 idle outputs", {req_ready, mem_cs_n, mem_frame_n, mem_bs_n, mem_rd_wr, mem_wdata_oe, rsp_valid}, 32'h7C);
        end else begin
            e = expq.pop_front();
            mem_wait = e.wt;
            chk(mem_bs_n == e.bs_n, "R4 bs_n", mem_bs_n, e.bs_n);
            chk(mem_cs_n == e.cs_n && mem_frame_n == e.fr_n, "R5 cs_n/frame_n",
                {mem_cs_n, mem_frame_n}, {e.cs_n, e.fr_n});
            chk(mem_rd_wr == e.rw && mem_wdata_oe == e.oe, "R10 rd_wr/oe", {mem_rd_wr, mem_wdata_oe}, {e.rw, e.oe});
            chk(rsp_valid == e.rsp && req_ready == 1'b0, "R9 rsp_valid/req_ready", {rsp_valid, req_ready}, {e.rsp, 1'b0});
            if (!e.cs_n) chk(mem_addr == e.addr, "R2 mem_addr", mem_addr, e.addr);
            if (e.oe) chk(mem_wdata == exp_wdata, "R10 mem_wdata", mem_wdata, exp_wdata);
            if (e.rsp) chk(rsp_rdata == exp_rdata, rd_tag, rsp_rdata, exp_rdata);
        end
    endtask

    function automatic cyc_t mk(input logic bs, cs, fr, rw, oe, wt, rsp, input logic [AW-1:0] a);
        cyc_t c;
        c.bs_n = bs; c.cs_n = cs; c.fr_n = fr; c.rw = rw; c.oe = oe; c.wt = wt; c.rsp = rsp; c.addr = a;
        return c;
    endfunction

    // one beat: start, wait cycles (mem_wait noise there), stretches, data
    task automatic push_beat(input bit wr, input logic [AW-1:0] a, input int w, input int s);
        logic fr = wr ? 1'b1 : 1'b0;
        logic rw = wr ? 1'b0 : 1'b1;
        expq.push_back(mk(0, 0, fr, rw, wr, 1, 0, a));
        for (int i = 0; i < w; i++) expq.push_back(mk(1, 0, fr, rw, wr, i[0], 0, a));
        for (int i = 0; i < s; i++) expq.push_back(mk(1, 0, fr, rw, wr, 1, 0, a));
        expq.push_back(mk(1, 0, fr, rw, wr, 0, 0, a));
    endtask

    task automatic run(input int busy_cycles);
        step();
        for (int i = 0; i < busy_cycles; i++) begin
            req_valid = 1; req_write = 1; req_addr = 24'hFFFFFF;
            step();
        end
        req_valid = 0;
        while (expq.size() > 0) step();
        step();
    endtask

    task automatic do_read(input logic [AW-1:0] a, input bit wide, input logic [31:0] stretch,
                           input int busy_cycles);
        logic [AW-1:0] base = {a[AW-1:4], 4'h0};
        logic [AW-1:0] pair = {a[AW-1:3], 3'b000} & ~24'h0 | {20'h0, a[3:2], 2'b00};
        req_valid = 1; req_write = 0; req_wide = wide; req_addr = a;
        for (int b = 0; b < 8; b++)
            push_beat(0, base | AW'(b * 2), (b == 0) ? int'(cfg_first_wait) : int'(cfg_next_wait),
                      int'(stretch[b*4 +: 4]));
        expq.push_back(mk(1, 1, 1, 1, 0, 0, 1, '0));
        if (wide) begin
            exp_rdata = {memf({pair[AW-1:2], 2'b00}), memf({pair[AW-1:2], 2'b10})};
            rd_tag = "R8 32-bit read data";
        end else begin
            exp_rdata = {16'h0, memf({a[AW-1:1], 1'b0})};
            rd_tag = "R7 16-bit read data";
        end
        run(busy_cycles);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d, input int s);
        req_valid = 1; req_write = 1; req_wide = 0; req_addr = a; req_wdata = d;
        exp_wdata = d;
        push_beat(1, a, int'(cfg_first_wait), s);
        expq.push_back(mk(1, 1, 1, 1, 0, 0, 1, '0));
        exp_rdata = 32'h0;
        rd_tag = "R10 write response data";
        run(0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        step();
        step();
        // R2 R3 32-bit read, waits 2/1
        do_read(24'h000104, 1, 32'h0, 0);
        // R11 zero waits, 16-bit read
        cfg_first_wait = 0; cfg_next_wait = 0;
        do_read(24'h00020E, 0, 32'h0, 0);
        // R6 stretched beats, R8 addr[1] ignored
        cfg_first_wait = 3; cfg_next_wait = 2;
        do_read(24'h00031A, 1, 32'h2010_0302, 0);
        // R9 requests during busy ignored
        cfg_first_wait = 1; cfg_next_wait = 0;
        do_read(24'h000500, 0, 32'h0000_0100, 5);
        // R7 last-beat halfword, R8 top pair
        do_read(24'h00061E, 0, 32'h1000_0000, 0);
        do_read(24'h00070C, 1, 32'h0, 0);
        // R10 writes
        cfg_first_wait = 1;
        do_write(24'h000401, 16'hBEEF, 2);
        cfg_first_wait = 0;
        do_write(24'h000822, 16'h1234, 0);
        // R3 large first wait
        cfg_first_wait = 5; cfg_next_wait = 3;
        do_read(24'h000906, 1, 32'h0, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule